// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block sits on the host side of a byte-wide parallel flash part. It writes a run of bytes into the part with a pulse-and-verify loop. A start pulse supplies a first address and a byte count. Data bytes come in one at a time from a valid/ready source. For each byte the block does the following:

- It issues a program-setup command, then a write that carries the target address and the data.
- It lets the program pulse settle for a timed interval.
- It sends the verify command, waits a second, shorter interval, and reads the byte back.
- If the byte does not match, it retries the same address. The number of attempts per byte is limited.

The block requests the high programming voltage for the whole run. It ends every run by putting the part back into array-read mode. It then reports completion, and on a failure it also reports the address that failed.

Both wait intervals are given in microseconds and scaled by the clock frequency parameter. Each bus access is one shared cycle of three phases: setup, strobe and hold. The strobe width is a parameter.

Top module: `fpgm_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fail`, `vpp_req` and `src_ready` are low, and all three flash strobes (`fl_ce_n`, `fl_we_n`, `fl_oe_n`) are high.
- R2: A start in idle raises `vpp_req` before the first flash write. `vpp_req` stays high through every write of the run, including the final read-mode command. It falls in the same cycle that `done` rises.
- R3: Every program attempt is two writes. The first carries command 40h. The second carries the target address with the data byte. No other write may come between them.
- R4: Between the rising write strobe of the address/data write and that of the following verify command (C0h), at least `CLK_MHZ*PGM_US` clock cycles pass.
- R5: Only after a C0h command is the byte read back, at the target address, with `fl_oe_n` low. The read strobe falls at least `CLK_MHZ*CHK_US` cycles after the C0h write strobe rises.
- R6: A matching read-back moves to the next address, modulo 2^ADDR_W. After the last byte the block writes 00h (array read) and then raises `done` with `fail` low. `done` stays high until the next start.
- R7: A mismatch retries the same address, starting again with a new 40h write. The attempt count restarts at zero for each new byte, so every byte gets the full budget of `MAX_PULSES` attempts.
- R8: If the byte still mismatches after `MAX_PULSES` attempts, the run stops. `fail` goes high, `fail_addr` holds that address, no further byte is fetched or programmed, 00h is written, and `done` rises.
- R9: A start with length 0 writes only the 00h command, takes no byte from the source, and finishes with `done` high and `fail` low.
- R10: Exactly one source byte is taken (a `src_valid` and `src_ready` handshake) per address attempted. While the block waits for a byte, `src_ready` is high and no flash access takes place (`fl_ce_n` high).
- R11: `fl_we_n` and `fl_oe_n` are never low together. `fl_ce_n` is low whenever either of them is low. Address and write data hold steady while `fl_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run (accepted only when idle) |
| start_addr | input | ADDR_W | First flash address of the run |
| length | input | LEN_W | Number of bytes to program |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block takes the source byte this cycle if valid |
| vpp_req | output | 1 | Request for the programming voltage |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Flash data bus, driven value |
| fl_dq_oe | output | 1 | Enable for the data bus drivers |
| fl_dq_in | input | 8 | Flash data bus, received value |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable (read strobe), active low |
| fl_we_n | output | 1 | Write enable (write strobe), active low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished (held until next start) |
| fail | output | 1 | Last run stopped on a byte that did not verify |
| fail_addr | output | ADDR_W | Address that failed verification |

## Verification
The embedded assertions assume that `fl_dq_in` carries the stored byte by the last cycle of a read strobe. They also assume that the source byte is taken only at the handshake edge, and that `start` can have an effect only when the block is idle. The bench flash model therefore drives read data combinationally for as long as `fl_oe_n` is low. The bench changes `src_valid` and `src_data` only away from the sampling edge, and it pulses `start` only once the previous run has reported `done`. The model also counts, per address, how many pulses a cell needs before it takes its data. This lets the stimulus reach the exact attempt limit and go one past it, without ever driving the block outside its stated input contract.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

   // Command bytes written to the flash part
   localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
   localparam logic [7:0] CMD_PGM_CHECK = 8'hC0;
   localparam logic [7:0] CMD_ARRAY_RD  = 8'h00;

   typedef enum logic {
      BOP_WRITE = 1'b0,
      BOP_READ  = 1'b1
   } bus_op_e;

   typedef enum logic [1:0] {
      BPH_IDLE,
      BPH_SETUP,
      BPH_STROBE,
      BPH_HOLD
   } bus_phase_e;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_SETUP_CMD,
      SQ_DATA_WR,
      SQ_PGM_WAIT,
      SQ_CHECK_CMD,
      SQ_CHECK_WAIT,
      SQ_CHECK_RD,
      SQ_EXIT_CMD
   } seq_state_e;

endpackage

// File: rtl/fpgm_wait_timer.sv
module fpgm_wait_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0) && !load;

   // A non-zero load must hold the wait open for at least the next cycle
   assert_wait_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/fpgm_bus_cycle.sv
module fpgm_bus_cycle
   import fpgm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned STROBE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  bus_op_e           op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              ack,
   output logic [7:0]        rdata,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_in,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n
);

   bus_phase_e        phase_q;
   bus_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        wdata_q;
   logic              strobe_last;

   // Strobe width: a single-cycle variant needs no counter
   generate
      if (STROBE_CYC == 1) begin : g_single
         assign strobe_last = 1'b1;
      end else begin : g_multi
         localparam int unsigned SC_W = $clog2(STROBE_CYC);
         logic [SC_W-1:0] sc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sc_q <= '0;
            end else if (phase_q == BPH_SETUP) begin
               sc_q <= SC_W'(STROBE_CYC - 1);
            end else if (phase_q == BPH_STROBE && sc_q != '0) begin
               sc_q <= sc_q - 1'b1;
            end
         end
         assign strobe_last = (sc_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= BPH_IDLE;
         op_q    <= BOP_WRITE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         unique case (phase_q)
            BPH_IDLE: begin
               if (req) begin
                  op_q    <= op;
                  addr_q  <= addr;
                  wdata_q <= wdata;
                  phase_q <= BPH_SETUP;
               end
            end
            BPH_SETUP:  phase_q <= BPH_STROBE;
            BPH_STROBE: begin
               if (strobe_last) begin
                  phase_q <= BPH_HOLD;
                  if (op_q == BOP_READ) begin
                     rdata <= fl_dq_in;
                  end
               end
            end
            BPH_HOLD:   phase_q <= BPH_IDLE;
            default:    phase_q <= BPH_IDLE;
         endcase
      end
   end

   assign ack       = (phase_q == BPH_HOLD);
   assign fl_addr   = addr_q;
   assign fl_dq_out = wdata_q;
   assign fl_dq_oe  = (phase_q != BPH_IDLE) && (op_q == BOP_WRITE);
   assign fl_ce_n   = (phase_q == BPH_IDLE);
   assign fl_we_n   = !((phase_q == BPH_STROBE) && (op_q == BOP_WRITE));
   assign fl_oe_n   = !((phase_q == BPH_STROBE) && (op_q == BOP_READ));

   assert_write_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |=> fl_we_n || ($stable(fl_addr) && $stable(fl_dq_out)));

   assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_dq_oe);

   assert_no_req_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !fl_ce_n);

endmodule

// File: rtl/fpgm_seq_ctrl.sv
module fpgm_seq_ctrl
   import fpgm_pkg::*;
#(
   parameter int unsigned ADDR_W       = 18,
   parameter int unsigned LEN_W        = 19,
   parameter int unsigned MAX_PULSES   = 25,
   parameter int unsigned PGM_WAIT_CYC = 1250,
   parameter int unsigned CHK_WAIT_CYC = 750,
   parameter int unsigned TMR_W        = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   input  logic              src_valid,
   input  logic [7:0]        src_data,
   output logic              src_ready,
   output logic              bus_req,
   output bus_op_e           bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata,
   output logic              tmr_load,
   output logic [TMR_W-1:0]  tmr_val,
   input  logic              tmr_expired,
   output logic              vpp_req,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr
);

   localparam int unsigned PC_W = $clog2(MAX_PULSES + 1);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [7:0]        byte_q;
   logic [PC_W-1:0]   pulses_q;
   logic              vpp_q;
   logic              done_q;
   logic              fail_q;
   logic [ADDR_W-1:0] fail_addr_q;
   logic              match;
   logic              at_limit;

   assign match    = (bus_rdata == byte_q);
   assign at_limit = (pulses_q == PC_W'(MAX_PULSES));

   always_comb begin
      bus_req   = 1'b0;
      bus_op    = BOP_WRITE;
      bus_wdata = byte_q;
      unique case (state_q)
         SQ_SETUP_CMD: begin bus_req = 1'b1; bus_wdata = CMD_PGM_SETUP; end
         SQ_DATA_WR:   begin bus_req = 1'b1; bus_wdata = byte_q;        end
         SQ_CHECK_CMD: begin bus_req = 1'b1; bus_wdata = CMD_PGM_CHECK; end
         SQ_CHECK_RD:  begin bus_req = 1'b1; bus_op = BOP_READ;         end
         SQ_EXIT_CMD:  begin bus_req = 1'b1; bus_wdata = CMD_ARRAY_RD;  end
         default:      bus_req = 1'b0;
      endcase
   end

   assign bus_addr  = addr_q;
   assign tmr_load  = bus_ack && (state_q == SQ_DATA_WR || state_q == SQ_CHECK_CMD);
   assign tmr_val   = (state_q == SQ_DATA_WR) ? TMR_W'(PGM_WAIT_CYC) : TMR_W'(CHK_WAIT_CYC);
   assign src_ready = (state_q == SQ_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         addr_q      <= '0;
         remain_q    <= '0;
         byte_q      <= '0;
         pulses_q    <= '0;
         vpp_q       <= 1'b0;
         done_q      <= 1'b0;
         fail_q      <= 1'b0;
         fail_addr_q <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  addr_q   <= start_addr;
                  remain_q <= length;
                  done_q   <= 1'b0;
                  fail_q   <= 1'b0;
                  vpp_q    <= 1'b1;
                  state_q  <= (length == '0) ? SQ_EXIT_CMD : SQ_FETCH;
               end
            end
            SQ_FETCH: begin
               if (src_valid) begin
                  byte_q   <= src_data;
                  pulses_q <= '0;
                  state_q  <= SQ_SETUP_CMD;
               end
            end
            SQ_SETUP_CMD: if (bus_ack) state_q <= SQ_DATA_WR;
            SQ_DATA_WR: begin
               if (bus_ack) begin
                  pulses_q <= pulses_q + 1'b1;
                  state_q  <= SQ_PGM_WAIT;
               end
            end
            SQ_PGM_WAIT:   if (tmr_expired) state_q <= SQ_CHECK_CMD;
            SQ_CHECK_CMD:  if (bus_ack) state_q <= SQ_CHECK_WAIT;
            SQ_CHECK_WAIT: if (tmr_expired) state_q <= SQ_CHECK_RD;
            SQ_CHECK_RD: begin
               if (bus_ack) begin
                  if (match) begin
                     if (remain_q == LEN_W'(1)) begin
                        state_q <= SQ_EXIT_CMD;
                     end else begin
                        addr_q   <= addr_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        state_q  <= SQ_FETCH;
                     end
                  end else if (at_limit) begin
                     fail_q      <= 1'b1;
                     fail_addr_q <= addr_q;
                     state_q     <= SQ_EXIT_CMD;
                  end else begin
                     state_q <= SQ_SETUP_CMD;
                  end
               end
            end
            SQ_EXIT_CMD: begin
               if (bus_ack) begin
                  vpp_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign vpp_req   = vpp_q;
   assign busy      = (state_q != SQ_IDLE);
   assign done      = done_q;
   assign fail      = fail_q;
   assign fail_addr = fail_addr_q;

   assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulses_q <= PC_W'(MAX_PULSES));

   assert_fail_reports_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_q && state_q == SQ_IDLE) |-> done_q);

   assert_retry_same_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_CHECK_RD && bus_ack && !match && !at_limit)
         |=> (state_q == SQ_SETUP_CMD && $stable(addr_q)));

   assert_fresh_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_FETCH && src_valid) |=> (pulses_q == '0));

   assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == SQ_IDLE));

endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
   import fpgm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned LEN_W      = 19,
   parameter int unsigned MAX_PULSES = 25,
   parameter int unsigned CLK_MHZ    = 125,
   parameter int unsigned PGM_US     = 10,
   parameter int unsigned CHK_US     = 6,
   parameter int unsigned STROBE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   input  logic              src_valid,
   input  logic [7:0]        src_data,
   output logic              src_ready,
   output logic              vpp_req,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_in,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr
);

   localparam int unsigned PGM_WAIT_CYC = CLK_MHZ * PGM_US;
   localparam int unsigned CHK_WAIT_CYC = CLK_MHZ * CHK_US;
   localparam int unsigned LONGEST_WAIT = (PGM_WAIT_CYC > CHK_WAIT_CYC) ? PGM_WAIT_CYC : CHK_WAIT_CYC;
   localparam int unsigned TMR_W        = $clog2(LONGEST_WAIT + 1);

   generate
      if (MAX_PULSES < 1 || PGM_WAIT_CYC < 1 || CHK_WAIT_CYC < 1 ||
          STROBE_CYC < 1 || ADDR_W < 1 || LEN_W < 1) begin : g_bad_cfg
         $error("fpgm_seq: attempt limit, wait cycles, strobe width and widths must be non-zero");
      end
   endgenerate

   bus_op_e           bus_op;
   logic              bus_req;
   logic [ADDR_W-1:0] bus_addr;
   logic [7:0]        bus_wdata;
   logic              bus_ack;
   logic [7:0]        bus_rdata;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_expired;

   fpgm_seq_ctrl #(
      .ADDR_W      (ADDR_W),
      .LEN_W       (LEN_W),
      .MAX_PULSES  (MAX_PULSES),
      .PGM_WAIT_CYC(PGM_WAIT_CYC),
      .CHK_WAIT_CYC(CHK_WAIT_CYC),
      .TMR_W       (TMR_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (start_addr),
      .length     (length),
      .src_valid  (src_valid),
      .src_data   (src_data),
      .src_ready  (src_ready),
      .bus_req    (bus_req),
      .bus_op     (bus_op),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .tmr_expired(tmr_expired),
      .vpp_req    (vpp_req),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .fail_addr  (fail_addr)
   );

   fpgm_wait_timer #(
      .CNT_W(TMR_W)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   fpgm_bus_cycle #(
      .ADDR_W    (ADDR_W),
      .STROBE_CYC(STROBE_CYC)
   ) bus_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (bus_req),
      .op       (bus_op),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .ack      (bus_ack),
      .rdata    (bus_rdata),
      .fl_addr  (fl_addr),
      .fl_dq_out(fl_dq_out),
      .fl_dq_oe (fl_dq_oe),
      .fl_dq_in (fl_dq_in),
      .fl_ce_n  (fl_ce_n),
      .fl_oe_n  (fl_oe_n),
      .fl_we_n  (fl_we_n)
   );

   assert_vpp_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> vpp_req);

   assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n));

   assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fl_ce_n && !vpp_req && !busy));

   assert_fetch_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> fl_ce_n);

endmodule

// File: tb/fpgm_seq_tb_top.sv
`timescale 1ns/1ps
module fpgm_seq_tb_top;

   localparam int AW     = 8;
   localparam int LW     = 9;
   localparam int MAXP   = 25;
   localparam int MHZ    = 2;   // scaled so waits stay short in the bench
   localparam int PGM_CY = MHZ * 10;
   localparam int CHK_CY = MHZ * 6;

   typedef enum int {M_READ, M_SETUP, M_PROGD, M_VERIFY} mode_e;

   typedef struct packed {
      logic [7:0] addr;
      logic [8:0] len;
      logic [7:0] stub;
      logic       stall;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{addr: 8'd10,  len: 9'd4, stub: 8'd1,  stall: 1'b0},
      '{addr: 8'd40,  len: 9'd3, stub: 8'd3,  stall: 1'b1},
      '{addr: 8'd100, len: 9'd2, stub: 8'd25, stall: 1'b0},
      '{addr: 8'd200, len: 9'd2, stub: 8'd26, stall: 1'b0},
      '{addr: 8'd254, len: 9'd3, stub: 8'd2,  stall: 1'b0},
      '{addr: 8'd0,   len: 9'd6, stub: 8'd1,  stall: 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [LW-1:0] length = '0;
   logic          src_valid;
   logic [7:0]    src_data;
   logic          src_ready;
   logic          vpp_req;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_dq_out;
   logic          fl_dq_oe;
   logic [7:0]    fl_dq_in;
   logic          fl_ce_n, fl_oe_n, fl_we_n;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;

   always #4 clk = ~clk;   // 125 MHz

   fpgm_seq #(
      .ADDR_W(AW), .LEN_W(LW), .MAX_PULSES(MAXP), .CLK_MHZ(MHZ),
      .PGM_US(10), .CHK_US(6), .STROBE_CYC(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .length(length), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .vpp_req(vpp_req), .fl_addr(fl_addr),
      .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
      .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
   );

   function automatic logic [7:0] dfn(int a);
      return 8'((a * 37 + 11) & 8'h7F);   // never the erased value FFh
   endfunction

   // ---------------- stimulus-side state (written by the initial block) ----
   int  errors = 0;
   int  checks = 0;
   int  need_init [256];
   int  case_a = 0;
   int  case_n = 0;
   bit  stall_en = 1'b0;
   bit  hold_off = 1'b0;
   bit  mdl_clear = 1'b1;

   // ---------------- source --------------------------------------------------
   int ncyc = 0;
   always @(negedge clk) ncyc <= ncyc + 1;

   int took = 0;
   assign src_valid = !hold_off && !(stall_en && (ncyc % 5 < 3));
   assign src_data  = dfn(case_a + took);

   // ---------------- flash model --------------------------------------------
   logic [7:0] mem [256];
   int    need [256];
   mode_e mode = M_READ;
   int    m_checks = 0;
   int    m_errors = 0;
   int    m_pulses = 0;
   int    m_cyc = 0;
   int    pgm_cyc = 0;
   int    chk_cyc = 0;
   int    pgm_addr = 0;
   int    last_wr = -1;
   logic  we_prev = 1'b1;
   logic  oe_prev = 1'b1;

   assign fl_dq_in = (mode == M_VERIFY && need[fl_addr] != 0) ? 8'hFF : mem[fl_addr];

   task automatic mchk(bit ok, string req, int act, int exp);
      m_checks++;
      if (!ok) begin
         m_errors++;
         $display("FAIL %s: flash model saw %0d, expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (mdl_clear) begin
         for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'hFF;
            need[i] = need_init[i];
         end
         mode     = M_READ;
         m_pulses = 0;
         last_wr  = -1;
         took    <= 0;
      end else if (rst_n) begin
         m_cyc++;
         if (src_valid && src_ready) took <= took + 1;
         if (we_prev && !fl_we_n) begin
            mchk(vpp_req == 1'b1, "R2 vpp during write", int'(vpp_req), 1);
            mchk(!fl_ce_n && fl_oe_n, "R11 write strobe", int'({fl_ce_n, fl_oe_n}), 1);
         end
         if (oe_prev && !fl_oe_n) begin
            mchk(!fl_ce_n && fl_we_n, "R11 read strobe", int'({fl_ce_n, fl_we_n}), 1);
            mchk(mode == M_VERIFY, "R5 read after C0h", int'(mode), int'(M_VERIFY));
            mchk(m_cyc - chk_cyc >= CHK_CY, "R5 verify wait", m_cyc - chk_cyc, CHK_CY);
            mchk(int'(fl_addr) == pgm_addr, "R5 read address", int'(fl_addr), pgm_addr);
         end
         if (!we_prev && fl_we_n) begin
            last_wr = int'(fl_dq_out);
            if (mode == M_SETUP) begin
               m_pulses++;
               pgm_cyc  = m_cyc;
               pgm_addr = int'(fl_addr);
               mode     = M_PROGD;
               if (need[fl_addr] > 0) begin
                  need[fl_addr] = need[fl_addr] - 1;
                  if (need[fl_addr] == 0) mem[fl_addr] = fl_dq_out;
               end
            end else if (fl_dq_out == 8'h40) begin
               mode = M_SETUP;
            end else if (fl_dq_out == 8'hC0) begin
               mchk(mode == M_PROGD, "R3 C0h after program write", int'(mode), int'(M_PROGD));
               mchk(m_cyc - pgm_cyc >= PGM_CY, "R4 program wait", m_cyc - pgm_cyc, PGM_CY);
               chk_cyc = m_cyc;
               mode    = M_VERIFY;
            end else if (fl_dq_out == 8'h00) begin
               mode = M_READ;
            end else begin
               mchk(1'b0, "R3 unexpected command", int'(fl_dq_out), 8'h40);
            end
         end
      end
      we_prev = fl_we_n;
      oe_prev = fl_oe_n;
   end

   // ---------------- bench checks -------------------------------------------
   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic prep(int a, int n, int stub, int sp_a, int sp_need, bit stall);
      for (int i = 0; i < 256; i++) need_init[i] = 0;
      for (int i = 0; i < n; i++) need_init[(a + i) % 256] = stub;
      if (sp_a >= 0) need_init[sp_a] = sp_need;
      case_a   = a;
      case_n   = n;
      stall_en = stall;
      @(negedge clk) mdl_clear = 1'b1;
      @(negedge clk) mdl_clear = 1'b0;
   endtask

   task automatic launch();
      @(negedge clk);
      start_addr = AW'(case_a);
      length     = LW'(case_n);
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic finish_case(string tag);
      bit seen = 1'b0;
      bit e_fail = 1'b0;
      int e_fa = 0;
      int e_pulses = 0;
      int e_took = 0;
      for (int k = 0; k < 40000; k++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
      chk(seen, "R6 done reached", int'(seen), 1);
      for (int i = 0; i < case_n; i++) begin
         int idx = (case_a + i) % 256;
         e_took++;
         if (need_init[idx] <= MAXP) begin
            e_pulses += need_init[idx];
         end else begin
            e_pulses += MAXP;
            e_fail = 1'b1;
            e_fa   = idx;
            break;
         end
      end
      $display("case %s: addr=%0d len=%0d pulses=%0d", tag, case_a, case_n, m_pulses);
      chk(fail == e_fail, "R8 fail flag", int'(fail), int'(e_fail));
      if (e_fail) chk(int'(fail_addr) == e_fa, "R8 fail address", int'(fail_addr), e_fa);
      chk(m_pulses == e_pulses, "R7 attempt count", m_pulses, e_pulses);
      chk(took == e_took, "R10 bytes taken", took, e_took);
      chk(last_wr == 0, "R6 final 00h command", last_wr, 0);
      chk(!vpp_req && !busy && fl_ce_n, "R2 vpp released at done", int'({vpp_req, busy, fl_ce_n}), 1);
      for (int i = 0; i < e_took; i++) begin
         int idx = (case_a + i) % 256;
         int ev  = (e_fail && idx == e_fa) ? 8'hFF : int'(dfn(case_a + i));
         chk(int'(mem[idx]) == ev, "R6 programmed byte", int'(mem[idx]), ev);
      end
      if (e_took < case_n) begin
         int idx = (case_a + e_took) % 256;
         chk(mem[idx] == 8'hFF, "R8 later byte untouched", int'(mem[idx]), 255);
      end
   endtask

   // ---------------- main sequence ------------------------------------------
   initial begin
      for (int i = 0; i < 256; i++) need_init[i] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      mdl_clear = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !fail, "R1 idle flags", int'({busy, done, fail}), 0);
      chk(!vpp_req && !src_ready, "R1 vpp and ready low", int'({vpp_req, src_ready}), 0);
      chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes high", int'({fl_ce_n, fl_we_n, fl_oe_n}), 7);

      // table of vectors: R3..R8, R10, R11 via the flash model
      for (int v = 0; v < NVEC; v++) begin
         prep(int'(VECS[v].addr), int'(VECS[v].len), int'(VECS[v].stub), -1, 0, VECS[v].stall);
         launch();
         finish_case($sformatf("vec%0d", v));
      end

      // R9: zero length
      prep(77, 0, 1, -1, 0, 1'b0);
      launch();
      finish_case("R9 zero length");
      chk(m_pulses == 0, "R9 no program write", m_pulses, 0);

      // R7/R8: second byte never verifies; first byte kept, third not fetched
      prep(60, 3, 2, 61, 30, 1'b0);
      launch();
      finish_case("R8 middle byte");

      // R10: source held off, block must wait without touching the bus
      prep(120, 2, 1, -1, 0, 1'b0);
      hold_off = 1'b1;
      launch();
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!fl_ce_n || !src_ready) quiet = 1'b0;
         end
         chk(quiet, "R10 waits quietly for source", int'(quiet), 1);
         chk(vpp_req && busy, "R2 vpp held while waiting", int'({vpp_req, busy}), 3);
      end
      hold_off = 1'b0;
      finish_case("R10 held source");

      $display("Result: errors=%0d of %0d checks", errors + m_errors, checks + m_checks);
      $finish;
   end

   initial begin
      #(8 * 190000);
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors + m_errors + 1, checks + m_checks + 1);
      $finish;
   end

endmodule